// File: doc/BRIEF.md
# Quarter-Wave Parabolic Sine and Cosine Unit

This block turns a fixed-point angle word into sine, negated sine and cosine values. It does not use an iterative rotation or a stored table. Instead it multiplies two second-order parabolic factors together, and each factor carries one fixed 7-bit coefficient. The angle word covers one full turn. The two upper bits pick the quarter of the circle, and the lower bits give the position inside that quarter as a fraction in [0,1).

All arithmetic takes place in the first quarter. A fold step picks either the fraction or its complement to one, and the squared term is shared between the sine path and the cosine path. After the product, each result is negated or passed through according to its quarter. The input word is registered, the three results are registered, and the logic between the two register stages is purely combinational. A new angle can be presented on every clock. The unit is meant to feed rotation arithmetic, for example the rotation stages of a matrix factorisation.

Top module: `psyn_sincos`

## Requirements
- R1: While `rst` is high at a rising edge, the internal angle register and all three outputs clear to zero.
- R2: An angle applied before rising edge k shows its results on the outputs after rising edge k+1. The outputs do not change at edge k.
- R3: `angle_i[FW+1:FW]` selects the quarter: 00 is 0 to 90 degrees, 01 is 90 to 180, 10 is 180 to 270 and 11 is 270 to 360. `angle_i[FW-1:0]` is the fraction f, so the angle is (quarter + f/2^FW) x 90 degrees.
- R4: `sin_o` is a two's-complement number with OW fractional bits. For every input code it differs from the true sine by less than 1.25 x 2^-9.
- R5: `cos_o` uses the same format and meets the same error bound against the true cosine for every input code.
- R6: `nsin_o` is always the exact two's-complement negation of `sin_o`.
- R7: A nonzero `sin_o` is negative exactly in quarters 10 and 11. A nonzero `cos_o` is negative exactly in quarters 01 and 10.
- R8: When the fraction is zero, the outputs are exact. Sine is 0, +1.0, 0 and -1.0 in quarters 00 to 11. Cosine is +1.0, 0, -1.0 and 0.
- R9: The magnitude of `sin_o` and of `cos_o` never exceeds 1.0, which is 2^OW.
- R10: Angles applied on consecutive cycles in any order give independent results, with no carry-over from one angle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| angle_i | input | FW+2 | Quarter bits on top, fraction below |
| sin_o | output | OW+2 | Sine, two's complement, OW fractional bits |
| nsin_o | output | OW+2 | Negated sine, same format |
| cos_o | output | OW+2 | Cosine, same format |

## Verification
Every result is due after the second rising edge that follows the angle being applied. The first edge loads the angle register and the second edge loads the output registers. The bench drives angles on falling edges and keeps the applied codes in a queue. On each falling edge it compares the outputs with the code applied two falling edges earlier. A dedicated step after reset checks that the outputs still show the old angle one cycle after the new one is applied, and show the new one a cycle later. Two passes cover every input code against a real-valued sine and cosine. One pass is ascending and the other is a scrambled order, which exercises back-to-back changes.

// File: rtl/psyn_pkg.sv
package psyn_pkg;

  // Coefficient width (fractional bits) and the two parabolic coefficients
  localparam int CW = 7;
  localparam logic [CW-1:0] C1 = 7'b1001001;  // 73/128
  localparam logic [CW-1:0] C2 = 7'b0110100;  // 52/128

  typedef enum logic [1:0] {
    QD_FIRST  = 2'b00,
    QD_SECOND = 2'b01,
    QD_THIRD  = 2'b10,
    QD_FOURTH = 2'b11
  } quad_e;

endpackage

// File: rtl/psyn_square.sv
// Computes x - x^2 for x in [0,1] with FW fractional bits.
// The result has 2*FW fractional bits and never exceeds 0.25.
module psyn_square #(
  parameter int FW = 10
) (
  input  logic [FW:0]     x,
  output logic [2*FW-1:0] d
);
  localparam int SQW = 2*FW + 2;
  localparam int DW  = 2*FW;

  assign d = DW'((SQW'(x) << FW) - SQW'(x) * SQW'(x));
endmodule

// File: rtl/psyn_mcm.sv
// Constant multiply by shift-add: sums d shifted to each set coefficient bit.
module psyn_mcm #(
  parameter int DW = 20,
  parameter int CW = 7,
  parameter logic [CW-1:0] COEF = '0
) (
  input  logic [DW-1:0]    d,
  output logic [DW+CW-1:0] p
);
  localparam int PW = DW + CW;

  logic [PW-1:0] acc [CW+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < CW; i++) begin : g_term
    if (COEF[i]) begin : g_add
      assign acc[i+1] = acc[i] + (PW'(d) << i);
    end else begin : g_pass
      assign acc[i+1] = acc[i];
    end
  end

  assign p = acc[CW];
endmodule

// File: rtl/psyn_factor.sv
// Forms the first factor lin + c1*(x - x^2) and multiplies it by the second
// factor. The product is rounded once, to OW fractional bits.
module psyn_factor #(
  parameter int FW = 10,
  parameter int CW = 7,
  parameter int OW = 12
) (
  input  logic [FW:0]          lin,
  input  logic [2*FW+CW-1:0]   t1,
  input  logic [2*FW+CW:0]     s2,
  output logic [OW:0]          mag
);
  localparam int TW = 2*FW + CW;
  localparam int SW = TW + 1;
  localparam int PW = 2*SW;
  localparam int SH = 2*TW - OW;
  localparam int MW = OW + 1;
  localparam logic [PW-1:0] RND = PW'(1) << (SH-1);

  logic [SW-1:0] s1;
  logic [PW-1:0] prod;

  assign s1   = (SW'(lin) << (FW + CW)) + SW'(t1);
  assign prod = PW'(s1) * PW'(s2);
  assign mag  = MW'((prod + RND) >> SH);
endmodule

// File: rtl/psyn_negate.sv
// Conditional two's-complement: an XOR row feeding a half-adder carry chain
// whose carry-in is the enable.
module psyn_negate #(
  parameter int W = 14
) (
  input  logic [W-1:0] a,
  input  logic         en,
  output logic [W-1:0] y
);
  logic [W-1:0] inv;
  logic [W-1:0] cy;

  assign cy[0] = en;

  for (genvar i = 0; i < W; i++) begin : g_ha
    assign inv[i] = a[i] ^ en;
    assign y[i]   = inv[i] ^ cy[i];
    if (i < W-1) begin : g_carry
      assign cy[i+1] = inv[i] & cy[i];
    end
  end
endmodule

// File: rtl/psyn_sincos.sv
module psyn_sincos
  import psyn_pkg::*;
#(
  parameter int FW = 10,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW+1:0] angle_i,
  output logic [OW+1:0] sin_o,
  output logic [OW+1:0] nsin_o,
  output logic [OW+1:0] cos_o
);
  localparam int AW = FW + 2;
  localparam int XW = FW + 1;
  localparam int DW = 2*FW;
  localparam int TW = DW + CW;
  localparam int MW = OW + 1;
  localparam int RW = OW + 2;
  localparam logic [RW-1:0] ONE_W = RW'(1) << OW;
  localparam logic [RW-1:0] NEG_W = ~ONE_W + RW'(1);
  localparam logic [XW-1:0] UNIT  = XW'(1) << FW;

  logic [AW-1:0] angle_q;
  quad_e         quad;
  logic [FW-1:0] frac;
  logic          fold, neg_sin, neg_cos;
  logic [XW-1:0] xs, xc;
  logic [DW-1:0] d;
  logic [TW-1:0] t1, t2;
  logic [TW:0]   s2;
  logic [MW-1:0] mag_s, mag_c;
  logic [RW-1:0] sin_n, nsin_n, cos_n;

  assign quad = quad_e'(angle_q[AW-1:FW]);
  assign frac = angle_q[FW-1:0];

  // Fold into the first quarter: sine takes the complement in quarters 2 and 4
  assign fold    = (quad == QD_SECOND) || (quad == QD_FOURTH);
  assign xs      = fold ? (UNIT - XW'(frac)) : XW'(frac);
  assign xc      = UNIT - xs;
  assign neg_sin = (quad == QD_THIRD) || (quad == QD_FOURTH);
  assign neg_cos = (quad == QD_SECOND) || (quad == QD_THIRD);

  // x - x^2 is symmetric about 0.5, so one squarer serves both paths
  psyn_square #(.FW(FW)) u_sq (.x(xs), .d(d));

  psyn_mcm #(.DW(DW), .CW(CW), .COEF(C1)) u_c1 (.d(d), .p(t1));
  psyn_mcm #(.DW(DW), .CW(CW), .COEF(C2)) u_c2 (.d(d), .p(t2));

  // Second factor: integer one wired above a fraction that stays below one
  assign s2 = {1'b1, t2};

  psyn_factor #(.FW(FW), .CW(CW), .OW(OW)) u_fs (
    .lin(xs), .t1(t1), .s2(s2), .mag(mag_s));
  psyn_factor #(.FW(FW), .CW(CW), .OW(OW)) u_fc (
    .lin(xc), .t1(t1), .s2(s2), .mag(mag_c));

  psyn_negate #(.W(RW)) u_ns (.a({1'b0, mag_s}), .en(neg_sin),  .y(sin_n));
  psyn_negate #(.W(RW)) u_nn (.a({1'b0, mag_s}), .en(!neg_sin), .y(nsin_n));
  psyn_negate #(.W(RW)) u_nc (.a({1'b0, mag_c}), .en(neg_cos),  .y(cos_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      angle_q <= '0;
      sin_o   <= '0;
      nsin_o  <= '0;
      cos_o   <= '0;
    end else begin
      angle_q <= angle_i;
      sin_o   <= sin_n;
      nsin_o  <= nsin_n;
      cos_o   <= cos_n;
    end
  end

  // R6
  neg_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (sin_o + nsin_o) == '0);

  // R9
  mag_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ($signed(sin_o) <= $signed(ONE_W)) && ($signed(sin_o) >= $signed(NEG_W)) &&
    ($signed(cos_o) <= $signed(ONE_W)) && ($signed(cos_o) >= $signed(NEG_W)));

  // R7
  sin_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sin_o != '0) |-> (sin_o[RW-1] == $past(angle_q[AW-1])));

  // R7
  cos_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cos_o != '0) |->
      (cos_o[RW-1] == ($past(angle_q[AW-1]) ^ $past(angle_q[AW-2]))));

  // R8
  edge_sin_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(angle_q[FW-1:0]) == '0) |->
      (sin_o == ($past(angle_q[FW]) ? ($past(angle_q[AW-1]) ? NEG_W : ONE_W) : '0)));

  // R8
  edge_cos_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(angle_q[FW-1:0]) == '0) |->
      (cos_o == ($past(angle_q[FW]) ? '0 : ($past(angle_q[AW-1]) ? NEG_W : ONE_W))));

endmodule

// File: tb/psyn_sincos_test.sv
module psyn_sincos_test;
  localparam int  FW    = 10;
  localparam int  OW    = 12;
  localparam int  AW    = FW + 2;
  localparam int  RW    = OW + 2;
  localparam int  NCODE = 1 << AW;
  localparam int  ONE   = 1 << OW;
  localparam real PI    = 3.14159265358979;
  localparam real TOL   = 1.25 / 512.0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] angle = '0;
  logic [RW-1:0] sin_o, nsin_o, cos_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int pend[$];

  always #10 clk = ~clk;

  psyn_sincos #(.FW(FW), .OW(OW)) uut (
    .clk(clk), .rst(rst), .angle_i(angle),
    .sin_o(sin_o), .nsin_o(nsin_o), .cos_o(cos_o));

  function automatic int sv(logic [RW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk_int(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_err(string tag, int code, real act, real exp);
    n_chk++;
    if ((act - exp > TOL) || (exp - act > TOL)) begin
      n_fail++;
      $display("FAIL %s code %0d: actual %f expected %f", tag, code, act, exp);
    end
  endtask

  // Reference check for the angle applied two cycles earlier
  task automatic compare(int code, bit sweep);
    int  qd, f, s, c, n, es_i, ec_i;
    real th, es, ec;
    qd = code >> FW;
    f  = code & ((1 << FW) - 1);
    th = (real'(qd) + real'(f) / real'(1 << FW)) * (PI / 2.0);
    es = $sin(th);
    ec = $cos(th);
    s  = sv(sin_o);
    c  = sv(cos_o);
    n  = sv(nsin_o);
    chk_err(sweep ? "R4 sin" : "R10 sin", code, real'(s) / real'(ONE), es);
    chk_err(sweep ? "R5 cos" : "R10 cos", code, real'(c) / real'(ONE), ec);
    chk_int("R6 nsin", n, -s);
    chk_int("R9 range", int'(s <= ONE && s >= -ONE && c <= ONE && c >= -ONE), 1);
    if (f == 0) begin
      es_i = (qd == 1) ? ONE : (qd == 3) ? -ONE : 0;
      ec_i = (qd == 0) ? ONE : (qd == 2) ? -ONE : 0;
      chk_int("R3 R8 sin boundary", s, es_i);
      chk_int("R3 R8 cos boundary", c, ec_i);
    end
    if (s != 0 && (es > 0.01 || es < -0.01))
      chk_int("R7 sin sign", int'(s < 0), int'(qd >= 2));
    if (c != 0 && (ec > 0.01 || ec < -0.01))
      chk_int("R7 cos sign", int'(c < 0), int'(qd == 1 || qd == 2));
  endtask

  task automatic step(int code, bit sweep);
    @(negedge clk);
    if (pend.size() == 2) compare(pend.pop_front(), sweep);
    angle = AW'(code);
    pend.push_back(code);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with a live angle on the input
    rst   = 1'b1;
    angle = AW'(1234);
    repeat (2) @(negedge clk);
    chk_int("R1 sin reset", sv(sin_o), 0);
    chk_int("R1 nsin reset", sv(nsin_o), 0);
    chk_int("R1 cos reset", sv(cos_o), 0);

    // R2: two-edge latency; second quarter, zero fraction gives sin +1
    rst   = 1'b0;
    angle = AW'(1 << FW);
    @(negedge clk);
    chk_int("R2 sin one cycle", sv(sin_o), 0);
    chk_int("R2 cos one cycle", sv(cos_o), ONE);
    @(negedge clk);
    chk_int("R2 sin two cycles", sv(sin_o), ONE);
    chk_int("R2 cos two cycles", sv(cos_o), 0);

    // Ascending sweep over every code
    for (int i = 0; i < NCODE; i++) step(i, 1'b1);
    // Scrambled order, back to back (R10)
    for (int i = 0; i < NCODE; i++) step((i * 613 + 77) % NCODE, 1'b0);
    step(0, 1'b0);
    step(0, 1'b0);

    // R1: reset in the middle of a stream
    @(negedge clk);
    rst = 1'b1;
    pend.delete();
    angle = AW'(3000);
    @(negedge clk);
    chk_int("R1 sin mid reset", sv(sin_o), 0);
    chk_int("R1 nsin mid reset", sv(nsin_o), 0);
    chk_int("R1 cos mid reset", sv(cos_o), 0);
    rst = 1'b0;

    step(3 << FW, 1'b1);
    step(2 << FW, 1'b1);
    step(NCODE - 1, 1'b1);
    step(1, 1'b1);
    step(0, 1'b1);
    step(0, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule